// File: doc/BRIEF.md
# Write Cycle Qualification Guard

This block stands between the active-low bus strobes of a memory (chip enable, output enable, write enable) and the command decoder behind them. It passes on a bus write only when that write is clearly deliberate. The strobe levels must form a legal write. Write enable must stay low long enough that it cannot be a noise spike. The power-up lockout window must be over. The supply must also be reported good.

When a write qualifies, the rising edge of write enable captures the address and data buses into output registers, and a single-cycle valid pulse goes to the decoder. All pins pass through synchronizers into the system clock domain. Pulse widths and the lockout length are therefore counted in clock cycles.

A supply-low flag from an external comparator blocks every write while it is asserted. It also holds the read output-enable off, so the data drivers stay high-impedance. When the supply returns, the lockout timer starts again from zero.

Top module: `cmd_write_guard`

## Requirements
- R1: While rst_ni is low, wr_valid_o and rd_oe_o are 0.
- R2: When write enable is sampled low on at least MIN_PULSE consecutive clock edges, with chip enable low and output enable high, and then rises while the other two strobes keep their levels, exactly one write is issued. wr_addr_o and wr_data_o then carry the address and data present at that rising edge. Address and data are held for at least SYNC_STAGES+2 cycles after the rise.
- R3: A write-enable pulse made while output enable is low issues no write.
- R4: A write-enable pulse made while chip enable is high issues no write.
- R5: A write-enable low pulse sampled on fewer than MIN_PULSE edges issues no write.
- R6: No write is issued until LOCK_CYCLES clock cycles have passed with the supply good since reset.
- R7: A write-enable low period that began during lockout, or while the supply was low, never qualifies, even if write enable rises after lockout ends.
- R8: While supply_ok_i is 0, no write is issued and rd_oe_o is 0.
- R9: A drop of supply_ok_i restarts the lockout, so writes stay blocked for LOCK_CYCLES cycles after the supply returns.
- R10: rd_oe_o is 1 exactly when chip enable and output enable are low and the supply is good, after SYNC_STAGES cycles of latency.
- R11: wr_valid_o is high for one cycle per write. wr_addr_o and wr_data_o keep their values until the next issued write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus write data |
| supply_ok_i | input | 1 | Supply good from the comparator (0 = supply low) |
| wr_valid_o | output | 1 | One-cycle pulse for a qualified write |
| wr_addr_o | output | ADDR_W | Address latched for the last write |
| wr_data_o | output | DATA_W | Data latched for the last write |
| rd_oe_o | output | 1 | Enable for the read data drivers |

## Verification
The assertions assume that the strobes and the supply flag reach the logic only through the synchronizers. Past values taken one or two cycles back are therefore clean, registered levels. They also assume that LOCK_CYCLES and MIN_PULSE are at least one. The bench drives every pin on the falling clock edge and counts pulse widths in whole clock edges. It holds address and data steady for several cycles after each write-enable rise, so that the latched values cannot depend on synchronizer latency.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic sup;
  } ctl_t;
  localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, sup: 1'b0};
endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/guard_lockout.sv
module guard_lockout #(
  parameter int LOCK_CYCLES = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_i,
  output logic open_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!sup_i)      cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = sup_i && (cnt_q == LIM);

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  // R9: supply loss restarts the window
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_i |=> cnt_q == '0);
endmodule

// File: rtl/guard_qualify.sv
module guard_qualify
  import guard_pkg::*;
#(
  parameter int MIN_PULSE = 2,
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int WCW = $clog2(MIN_PULSE + 1);
  localparam logic [WCW-1:0] WMAX = WCW'(MIN_PULSE);

  logic [WCW-1:0] wcnt_q;
  logic           taint_q;
  logic           wr_cond, accept;

  assign wr_cond = !ctl_i.ce_n && !ctl_i.we_n && ctl_i.oe_n;

  // a low period touched by lockout stays disqualified until it ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q  <= '0;
      taint_q <= 1'b0;
    end else if (!wr_cond) begin
      wcnt_q  <= '0;
      taint_q <= 1'b0;
    end else if (!open_i) begin
      wcnt_q  <= '0;
      taint_q <= 1'b1;
    end else if (!taint_q && wcnt_q < WMAX) begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign accept = (wcnt_q == WMAX) && ctl_i.we_n && !ctl_i.ce_n && ctl_i.oe_n && open_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= accept;
      if (accept) begin
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end
    end
  end

  p_one_cycle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
  p_legal_levels_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(!ctl_i.ce_n && ctl_i.oe_n && ctl_i.we_n));
  p_we_was_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(ctl_i.we_n, 2) == 1'b0);
  p_wcnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= WMAX);
endmodule

// File: rtl/cmd_write_guard.sv
module cmd_write_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 2,
  parameter int LOCK_CYCLES = 1_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              supply_ok_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_oe_o
);
  localparam int CTL_W = $bits(ctl_t);

  ctl_t ctl_raw, ctl_s;
  logic open;

  assign ctl_raw = '{ce_n: ce_ni, oe_n: oe_ni, we_n: we_ni, sup: supply_ok_i};

  guard_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync (
    .clk_i, .rst_ni, .d_i(ctl_raw), .q_o(ctl_s)
  );

  guard_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i, .rst_ni, .sup_i(ctl_s.sup), .open_o(open)
  );

  guard_qualify #(.MIN_PULSE(MIN_PULSE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qual (
    .clk_i, .rst_ni, .ctl_i(ctl_s), .open_i(open),
    .addr_i, .data_i, .wr_valid_o, .wr_addr_o, .wr_data_o
  );

  assign rd_oe_o = ctl_s.sup && !ctl_s.ce_n && !ctl_s.oe_n;

  p_locked_no_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(open));
  p_sup_low_no_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(ctl_s.sup));
  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !wr_valid_o && !rd_oe_o);
endmodule

// File: tb/sim_cmd_write_guard.sv
module sim_cmd_write_guard;
  localparam int AW = 19, DW = 8, LOCK = 64, MINP = 4;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, sup = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic wr_valid, rd_oe;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  int checks = 0, errors = 0, pulses = 0;

  always #2.5 clk = ~clk;

  cmd_write_guard #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2),
                    .MIN_PULSE(MINP), .LOCK_CYCLES(LOCK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(data), .supply_ok_i(sup),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_oe_o(rd_oe)
  );

  always @(posedge clk) if (rst_n && wr_valid) pulses++;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // write attempt; returns number of wr_valid cycles seen
  task automatic attempt(input logic c, input logic o, input int low,
                         input logic [AW-1:0] a, input logic [DW-1:0] d, output int n);
    int p0 = pulses;
    @(negedge clk); ce_n = c; oe_n = o; addr = a; data = d;
    cyc(1); we_n = 0;
    cyc(low); we_n = 1;
    cyc(8); ce_n = 1; oe_n = 1;
    cyc(4);
    n = pulses - p0;
  endtask

  task automatic t_powerup_we_low();
    int p0;
    rst_n = 0; ce_n = 0; oe_n = 1; we_n = 0;
    cyc(3);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 rd_oe", rd_oe, 0);
    p0 = pulses;
    rst_n = 1;
    cyc(LOCK + 20);
    we_n = 1;
    cyc(10); ce_n = 1;
    chk("R7 strobe from lockout", pulses - p0, 0);
  endtask

  task automatic t_good_write();
    int n;
    attempt(0, 1, MINP, 19'h2A5A5, 8'h3C, n);
    chk("R2 write issued", n, 1);
    chk("R11 one cycle", n, 1);
    chk("R2 addr", wr_addr, 19'h2A5A5);
    chk("R2 data", wr_data, 8'h3C);
    attempt(0, 1, MINP + 5, 19'h01234, 8'hC3, n);
    chk("R2 long pulse", n, 1);
    chk("R2 data 2", wr_data, 8'hC3);
  endtask

  task automatic t_glitch();
    int n;
    attempt(0, 1, MINP - 1, 19'h7, 8'h11, n);
    chk("R5 short pulse", n, 0);
    attempt(0, 1, 1, 19'h7, 8'h11, n);
    chk("R5 one-edge pulse", n, 0);
    chk("R11 data held", wr_data, 8'hC3);
  endtask

  task automatic t_logic_inhibit();
    int n;
    attempt(0, 0, MINP + 2, 19'h55, 8'h22, n);
    chk("R3 oe low", n, 0);
    attempt(1, 1, MINP + 2, 19'h55, 8'h22, n);
    chk("R4 ce high", n, 0);
    chk("R11 addr held", wr_addr, 19'h01234);
  endtask

  task automatic t_read_enable();
    @(negedge clk); ce_n = 0; oe_n = 0;
    cyc(3);
    chk("R10 rd_oe on", rd_oe, 1);
    ce_n = 1; cyc(3);
    chk("R10 rd_oe off ce", rd_oe, 0);
    ce_n = 0; oe_n = 1; cyc(3);
    chk("R10 rd_oe off oe", rd_oe, 0);
    ce_n = 1;
  endtask

  task automatic t_supply();
    int n;
    @(negedge clk); sup = 0; cyc(4);
    ce_n = 0; oe_n = 0; cyc(3);
    chk("R8 rd_oe forced off", rd_oe, 0);
    ce_n = 1; oe_n = 1;
    attempt(0, 1, MINP + 2, 19'h9, 8'h99, n);
    chk("R8 write blocked", n, 0);
    sup = 1;
    attempt(0, 1, MINP + 2, 19'h9, 8'h99, n);
    chk("R9 relocked after supply return", n, 0);
    cyc(LOCK + 10);
    attempt(0, 1, MINP, 19'hA, 8'h5A, n);
    chk("R9 write after relock", n, 1);
    chk("R9 data", wr_data, 8'h5A);
  endtask

  task automatic t_reset_lockout();
    int n;
    @(negedge clk); rst_n = 0; cyc(2); rst_n = 1;
    attempt(0, 1, MINP + 2, 19'h3, 8'h77, n);
    chk("R6 locked after reset", n, 0);
    cyc(LOCK);
    attempt(0, 1, MINP, 19'h3, 8'h77, n);
    chk("R6 open after window", n, 1);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        t_powerup_we_low();
        t_good_write();
        t_glitch();
        t_logic_inhibit();
        t_read_enable();
        t_supply();
        t_reset_lockout();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
      end
    join_any
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule